// File: doc/BRIEF.md
# Multi-Source Reset Controller with Strap Capture

This block merges four reset requests into one internal core reset and one board-level reset-out pin. Two requests are asynchronous pins: the external board reset and the PCI bus reset. Together they are the hard resets. The other two are synchronous pulses: a watchdog timeout and a software kick written through a control register port. Hard resets assert at once, with no clock needed, and are released through a two-stage synchronizer on the core clock. Soft resets pull the core reset low for a fixed number of core clocks and leave the control register and all latched straps untouched.

The block also captures board configuration straps. The general strap bus and the reset-out strap follow the external reset pin only. The wide-board strap follows the PCI reset only, taken from the inverted level of the request-64 pin. The reset-out pin is set by the latched reset-out strap until software sets an enable bit in the control register. From then on, a software hold bit in the same register decides the pin.

Top module: `rst_hub`

## Requirements
- R1: While `ext_rst_n` is low, `core_rst_n` and `rst_out_n` are both low, asynchronously and without any clock edge.
- R2: After a hard reset pin rises with the other hard reset pin high, `core_rst_n` stays low at the first rising clock edge and is high after the second.
- R3: While `pci_rst_n` is low, `core_rst_n` is low asynchronously.
- R4: `strap_q` loads `strap_pins` on every clock while the synchronized external reset is asserted, and then holds. PCI, watchdog and software resets leave it unchanged.
- R5: `board_wide_q` loads the inverse of `req64_n` on every clock while the synchronized PCI reset is asserted, and then holds. It is unaffected by the external reset pin.
- R6: Control register bit 22 is the reset-out enable and bit 21 is the reset-out hold. Both clear to 0 whenever either hard reset is asserted.
- R7: With the enable bit 0 and the external reset released, `rst_out_n` equals the reset-out strap latched under R4. A latched 1 releases the pin and a latched 0 keeps it asserted.
- R8: With the enable bit 1 and the external reset released, `rst_out_n` is the inverse of the hold bit. A register write takes effect at the clock edge that samples it.
- R9: A write with bit 0 set pulls `core_rst_n` low for exactly 16 cycles, starting at the edge that samples the write. Bits 22 and 21 of that write are stored, and the control register is retained through the pulse.
- R10: A one-cycle `wdog_expire` pulse with the core out of reset pulls `core_rst_n` low for exactly 16 cycles, starting at the edge that samples it.
- R11: While `core_rst_n` is low, register writes and watchdog pulses are ignored. They neither change the register nor extend the pulse.
- R12: The external reset pin asserting during a soft pulse forces reset at once and cancels the remaining count. After release, R2 timing applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| ext_rst_n | input | 1 | External board reset pin, active low, asynchronous |
| pci_rst_n | input | 1 | PCI bus reset pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog timeout pulse, synchronous to clk |
| sw_wr_en | input | 1 | Control register write strobe |
| sw_wr_data | input | 32 | Control write data: bit 22 enable, bit 21 hold, bit 0 software reset kick |
| strap_pins | input | 8 | General board strap inputs |
| rstout_strap_pin | input | 1 | Strap choosing the reset-out level while the enable bit is 0 |
| req64_n | input | 1 | Request-64 pin level, sampled for the wide-board strap |
| core_rst_n | output | 1 | Internal core reset, active low |
| rst_out_n | output | 1 | Board reset-out pin, active low |
| strap_q | output | 8 | Latched general straps |
| board_wide_q | output | 1 | Latched wide-board strap, 1 when `req64_n` was low at PCI reset release |

## Verification
The hardest case to reach is an external reset arriving in the middle of a running soft pulse. The check needs a count still pending when the pin drops, and a release that comes well before 16 cycles would have elapsed. The stimulus therefore starts a watchdog pulse, lowers the external pin partway into the count, and releases it after two cycles. The core reset must then come back after exactly two edges rather than at the old pulse end. A second hard case is proving that writes made during a pulse are dropped. This is seen at the reset-out pin: the dropped write would have cleared the enable bit and handed the pin back to a strap latched as 0.

// File: rtl/rst_hub.sv
module rst_hub #(
  parameter int STRAP_W     = 8,
  parameter int CTRL_W      = 32,
  parameter int EN_BIT      = 22,
  parameter int HOLD_BIT    = 21,
  parameter int KICK_BIT    = 0,
  parameter int SOFT_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               pci_rst_n,
  input  logic               wdog_expire,
  input  logic               sw_wr_en,
  input  logic [CTRL_W-1:0]  sw_wr_data,
  input  logic [STRAP_W-1:0] strap_pins,
  input  logic               rstout_strap_pin,
  input  logic               req64_n,
  output logic               core_rst_n,
  output logic               rst_out_n,
  output logic [STRAP_W-1:0] strap_q,
  output logic               board_wide_q
);

  localparam int CNT_W = $clog2(SOFT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] ext_sync, pci_sync;
  logic                   ext_ok, pci_ok, hard_n;
  logic                   ctrl_en, ctrl_hold, rstout_q;
  logic [CNT_W-1:0]       soft_cnt;
  logic                   soft_idle, wr_ok, kick;
  logic                   unused_wr_bits;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) ext_sync <= '0;
    else            ext_sync <= {ext_sync[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge pci_rst_n)
    if (!pci_rst_n) pci_sync <= '0;
    else            pci_sync <= {pci_sync[SYNC_STAGES-2:0], 1'b1};

  assign ext_ok = ext_sync[SYNC_STAGES-1];
  assign pci_ok = pci_sync[SYNC_STAGES-1];
  assign hard_n = ext_ok & pci_ok;

  assign soft_idle  = (soft_cnt == '0);
  assign core_rst_n = hard_n & soft_idle;
  assign wr_ok      = sw_wr_en & core_rst_n;
  assign kick       = core_rst_n & (wdog_expire | (sw_wr_en & sw_wr_data[KICK_BIT]));

  always_ff @(posedge clk or negedge hard_n)
    if (!hard_n)     soft_cnt <= '0;
    else if (kick)   soft_cnt <= CNT_W'(SOFT_CYCLES);
    else if (!soft_idle) soft_cnt <= soft_cnt - 1'b1;

  always_ff @(posedge clk or negedge hard_n)
    if (!hard_n) begin
      ctrl_en   <= 1'b0;
      ctrl_hold <= 1'b0;
    end else if (wr_ok) begin
      ctrl_en   <= sw_wr_data[EN_BIT];
      ctrl_hold <= sw_wr_data[HOLD_BIT];
    end

  always_ff @(posedge clk)
    if (!ext_ok) begin
      strap_q  <= strap_pins;
      rstout_q <= rstout_strap_pin;
    end

  always_ff @(posedge clk)
    if (!pci_ok) board_wide_q <= ~req64_n;

  assign rst_out_n = ext_ok & (ctrl_en ? ~ctrl_hold : rstout_q);

  assign unused_wr_bits = ^sw_wr_data;

endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
  parameter int STRAP_W = 8
) (
  input logic               clk,
  input logic               ext_rst_n,
  input logic               pci_rst_n,
  input logic               wdog_expire,
  input logic               core_rst_n,
  input logic               rst_out_n,
  input logic [STRAP_W-1:0] strap_q,
  input logic               board_wide_q,
  input logic               ext_ok,
  input logic               pci_ok,
  input logic               ctrl_en
);

  always @(posedge clk) begin
    if (ext_rst_n === 1'b0)
      AST_EXT_FORCES_LOW: assert (!core_rst_n && !rst_out_n); // R1
    if (pci_rst_n === 1'b0)
      AST_PCI_FORCES_LOW: assert (!core_rst_n); // R3
    if (ext_ok === 1'b0 || pci_ok === 1'b0)
      AST_CTRL_CLEARED: assert (!ctrl_en); // R6
  end

  AST_RELEASE_TWO_EDGES: assert property (@(posedge clk) disable iff (!ext_rst_n || !pci_rst_n)
    $rose(ext_rst_n) && pci_ok |-> !core_rst_n ##1 !core_rst_n ##1 core_rst_n); // R2

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!ext_rst_n)
    ext_ok |=> $stable(strap_q)); // R4

  AST_WIDE_HELD: assert property (@(posedge clk) disable iff (!pci_rst_n)
    pci_ok |=> $stable(board_wide_q)); // R5

  AST_WDOG_STARTS: assert property (@(posedge clk) disable iff (!ext_rst_n || !pci_rst_n)
    core_rst_n && wdog_expire |=> !core_rst_n); // R10

endmodule

bind rst_hub rst_hub_chk #(.STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .pci_rst_n(pci_rst_n), .wdog_expire(wdog_expire),
  .core_rst_n(core_rst_n), .rst_out_n(rst_out_n), .strap_q(strap_q),
  .board_wide_q(board_wide_q), .ext_ok(ext_ok), .pci_ok(pci_ok), .ctrl_en(ctrl_en)
);

// File: tb/test_rst_hub.sv
module test_rst_hub;
  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0, pci_rst_n = 1'b0, wdog_expire = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [7:0]  strap_pins = 8'hA5;
  logic        rstout_strap_pin = 1'b0, req64_n = 1'b0;
  logic        core_rst_n, rst_out_n, board_wide_q;
  logic [7:0]  strap_q;

  rst_hub i_rst_hub (
    .clk(clk), .ext_rst_n(ext_rst_n), .pci_rst_n(pci_rst_n), .wdog_expire(wdog_expire),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .strap_pins(strap_pins),
    .rstout_strap_pin(rstout_strap_pin), .req64_n(req64_n), .core_rst_n(core_rst_n),
    .rst_out_n(rst_out_n), .strap_q(strap_q), .board_wide_q(board_wide_q)
  );

  always #5 clk = ~clk;

  typedef struct {
    int         cyc;
    string      tag;
    int         sig;
    logic [7:0] val;
  } item_t;

  item_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] probe(int sig);
    case (sig)
      0: return {7'b0, core_rst_n};
      1: return {7'b0, rst_out_n};
      2: return strap_q;
      default: return {7'b0, board_wide_q};
    endcase
  endfunction

  function automatic string sname(int sig);
    case (sig)
      0: return "core_rst_n";
      1: return "rst_out_n";
      2: return "strap_q";
      default: return "board_wide_q";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic expect_at(int d, string tag, int sig, logic [7:0] v);
    item_t it;
    it.cyc = cyc + d; it.tag = tag; it.sig = sig; it.val = v;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        check(q[i].tag, sname(q[i].sig), probe(q[i].sig), q[i].val);
        q.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [31:0] d);
    sw_wr_en = 1'b1; sw_wr_data = d;
    step(1);
    sw_wr_en = 1'b0; sw_wr_data = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  localparam logic [31:0] EN = 32'h1 << 22, HOLD = 32'h1 << 21, KICK = 32'h1;

  initial begin
    step(4);
    check("R1", "core_rst_n in reset", {7'b0, core_rst_n}, 8'h0);
    check("R1", "rst_out_n in reset", {7'b0, rst_out_n}, 8'h0);
    ext_rst_n = 1'b1; pci_rst_n = 1'b1;
    expect_at(1, "R2", 0, 8'h0);
    expect_at(2, "R2", 0, 8'h1);
    expect_at(2, "R7", 1, 8'h0);
    expect_at(2, "R4", 2, 8'hA5);
    expect_at(2, "R5", 3, 8'h1);
    step(3); strap_pins = 8'h3C;
    expect_at(1, "R4", 2, 8'hA5);
    step(2);
    reg_write(EN);
    expect_at(0, "R8", 1, 8'h1);
    step(2);
    expect_at(1, "R8", 1, 8'h0);
    reg_write(EN | HOLD);
    expect_at(1, "R8", 1, 8'h1);
    reg_write(EN);
    step(2);
    // watchdog pulse, then dropped write and dropped watchdog inside it
    wdog_expire = 1'b1;
    expect_at(1, "R10", 0, 8'h0);
    expect_at(16, "R10", 0, 8'h0);
    expect_at(17, "R10", 0, 8'h1);
    expect_at(8, "R9", 1, 8'h1);
    expect_at(17, "R11", 1, 8'h1);
    expect_at(17, "R4", 2, 8'hA5);
    step(1); wdog_expire = 1'b0;
    step(2);
    reg_write(32'h0);
    step(1);
    wdog_expire = 1'b1;
    expect_at(12, "R11", 0, 8'h1);
    expect_at(14, "R11", 0, 8'h1);
    step(1); wdog_expire = 1'b0;
    step(16);
    // software kick
    sw_wr_en = 1'b1; sw_wr_data = EN | KICK;
    expect_at(1, "R9", 0, 8'h0);
    expect_at(16, "R9", 0, 8'h0);
    expect_at(17, "R9", 0, 8'h1);
    expect_at(17, "R9", 1, 8'h1);
    step(1); sw_wr_en = 1'b0; sw_wr_data = '0;
    step(20);
    // PCI reset
    pci_rst_n = 1'b0; req64_n = 1'b1; strap_pins = 8'hFF;
    #1;
    check("R3", "core_rst_n in PCI reset", {7'b0, core_rst_n}, 8'h0);
    check("R6", "rst_out_n after ctrl clear", {7'b0, rst_out_n}, 8'h0);
    step(3);
    pci_rst_n = 1'b1;
    expect_at(1, "R3", 0, 8'h0);
    expect_at(2, "R3", 0, 8'h1);
    expect_at(2, "R5", 3, 8'h0);
    expect_at(2, "R4", 2, 8'hA5);
    expect_at(2, "R6", 1, 8'h0);
    step(3); req64_n = 1'b0;
    expect_at(2, "R5", 3, 8'h0);
    step(4);
    // external reset with new straps
    ext_rst_n = 1'b0; strap_pins = 8'h5A; rstout_strap_pin = 1'b1;
    #1;
    check("R1", "core_rst_n on ext assert", {7'b0, core_rst_n}, 8'h0);
    check("R1", "rst_out_n on ext assert", {7'b0, rst_out_n}, 8'h0);
    step(3);
    ext_rst_n = 1'b1;
    expect_at(2, "R2", 0, 8'h1);
    expect_at(2, "R7", 1, 8'h1);
    expect_at(2, "R4", 2, 8'h5A);
    expect_at(2, "R5", 3, 8'h0);
    step(6);
    // external reset cutting a soft pulse short
    wdog_expire = 1'b1;
    step(1); wdog_expire = 1'b0;
    step(3);
    #2 ext_rst_n = 1'b0;
    #1 check("R12", "core_rst_n on ext during pulse", {7'b0, core_rst_n}, 8'h0);
    step(2);
    ext_rst_n = 1'b1;
    expect_at(1, "R12", 0, 8'h0);
    expect_at(2, "R12", 0, 8'h1);
    expect_at(6, "R12", 0, 8'h1);
    step(10);
    while (q.size() > 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s %s never sampled expected=%h", q[0].tag, sname(q[0].sig), q[0].val);
      q.delete(0);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule